// File: doc/BRIEF.md
# SDRAM Mode-Programmed Column Burst Sequencer

This block reproduces the column side of an SDRAM device once its mode word has been loaded. A mode-load strobe presents a 13-bit op-code. The block decodes four settings from it: the burst length, the wrap order, the read latency and a write override. An op-code that uses any reserved or test encoding is rejected as a whole. In that case the block raises a flag and keeps the settings it had before.

A READ or WRITE command carries a starting column. From the edge that registers the command, the block emits one column address per clock, in the order that the stored settings define. For a read, each address beat also travels down a latency pipeline. That pipeline yields a data-bus output enable, and one cycle later a data-valid strobe. A later READ or WRITE cuts a running burst short and starts its own burst immediately. A burst-stop command halts address generation, while read beats already issued still drain through the pipeline.

Top module: `sdr_burst_seq`

## Requirements
- R1: Mode bits [2:0] set the burst length: codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. After that many beats `col_valid` falls, unless a new command arrives first.
- R2: Burst-length code 111 with bit 3 clear selects a full-page burst. The address steps through all 2^COL_W columns and wraps from the last column to column 0. It runs until a command stops it.
- R3: With mode bit 3 clear (sequential), beat k carries the start column's low log2(length) bits plus k, modulo the length. The upper bits are copied from the start column.
- R4: With mode bit 3 set (interleaved), beat k is the start column with its low log2(length) bits XORed with k.
- R5: Mode bits [6:4] equal to 010 give a read latency m of 2, and 011 give m of 3. For a READ registered at edge n, `rd_oe` is high after edges n+m-1 through n+m+length-2. `rd_valid` is high for the same span shifted one cycle later.
- R6: With mode bit 9 set, a WRITE emits exactly one beat, while a READ still uses the programmed length. A WRITE beat never raises `rd_oe` or `rd_valid`.
- R7: A load is rejected if bits [12:10] are not 000, or bits [8:7] are not 00. It is also rejected for a latency code other than 010 or 011, for a length code of 100 to 110, or for code 111 together with bit 3 set. A rejected load sets `mode_illegal` and leaves every setting unchanged. A valid load clears `mode_illegal`.
- R8: The `cmd` code 1 is READ and code 2 is WRITE. Either command, even in the middle of a burst, puts its own start column on `col_addr` after the registering edge and sets `col_is_wr` to its type. It restarts the beat count.
- R9: The `cmd` code 3 stops the burst, and `col_valid` is low after that edge. Read beats already issued still produce their `rd_oe` and `rd_valid` cycles. Code 0 is no operation.
- R10: Synchronous reset clears every output. It sets burst length 1, sequential order, latency 2 and writes that follow the burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Strobe that loads `mode_op` |
| mode_op | input | 13 | Mode op-code |
| cmd | input | 2 | Command: 0 no-op, 1 read, 2 write, 3 burst stop |
| cmd_col | input | COL_W | Starting column of a read or write |
| col_valid | output | 1 | A column beat is present |
| col_addr | output | COL_W | Column address of the current beat |
| col_is_wr | output | 1 | Current beat belongs to a write |
| rd_oe | output | 1 | Data-bus output enable for read data |
| rd_valid | output | 1 | Read data valid strobe |
| mode_illegal | output | 1 | The last mode load was rejected |

## Verification
The bench builds the block with its default parameters: COL_W of 10 (a 1024-column page) and MAX_LAT of 3. The 1024-column page is small enough that a full-page burst started near the top of the row crosses the wrap from column 1023 to 0 and keeps running. The burst-stop command can then be applied within about a thousand cycles. A MAX_LAT of 3 puts both legal read latencies into the pipeline, so the enable and valid windows are checked at each latency. The same parameter values also exercise truncation while read beats are still in flight.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    localparam int MODE_W = 13;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_TERM  = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [1:0] len_log2;
        logic       full_page;
        logic       interleave;
        logic [1:0] cas_lat;
        logic       write_single;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{
        len_log2:     2'd0,
        full_page:    1'b0,
        interleave:   1'b0,
        cas_lat:      2'd2,
        write_single: 1'b0
    };

    // Whole op-code is accepted only when no field uses a reserved value.
    function automatic logic op_legal(input logic [MODE_W-1:0] op);
        logic len_ok;
        logic lat_ok;
        len_ok = (op[2:0] <= 3'd3) || ((op[2:0] == 3'd7) && !op[3]);
        lat_ok = (op[6:4] == 3'b010) || (op[6:4] == 3'b011);
        return (op[12:10] == 3'b000) && (op[8:7] == 2'b00) && len_ok && lat_ok;
    endfunction

    function automatic burst_cfg_t op_decode(input logic [MODE_W-1:0] op);
        burst_cfg_t c;
        c.full_page    = (op[2:0] == 3'd7);
        c.len_log2     = c.full_page ? 2'd0 : op[1:0];
        c.interleave   = op[3];
        c.cas_lat      = op[5:4];
        c.write_single = op[9];
        return c;
    endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] op,
    output burst_cfg_t        cfg,
    output logic              illegal
);

    burst_cfg_t cfg_q;
    logic       illegal_q;
    logic       op_ok;

    always_comb op_ok = op_legal(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            illegal_q <= 1'b0;
        end else if (load) begin
            illegal_q <= !op_ok;
            if (op_ok) cfg_q <= op_decode(op);
        end
    end

    assign cfg     = cfg_q;
    assign illegal = illegal_q;

    // R7: a rejected load leaves settings untouched and raises the flag
    p_reject_keeps_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        (load && !op_ok) |=> (cfg_q == $past(cfg_q)) && illegal_q);

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_burst_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  cmd_e             cmd,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [1:0]       len_log2,
    input  logic             full_page,
    input  logic             interleave,
    input  logic             write_single,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_is_wr
);

    logic             valid_q;
    logic [COL_W-1:0] addr_q;
    logic             wr_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] idx_q;
    logic [1:0]       blg_q;
    logic             full_q;
    logic             ilv_q;
    logic             last_q;

    logic             is_wr;
    logic             single;
    logic [1:0]       eff_blg;
    logic             eff_full;
    logic [COL_W-1:0] len_m1;
    logic [COL_W-1:0] mask_q;

    function automatic logic [COL_W-1:0] beat_addr(
        input logic [COL_W-1:0] base,
        input logic [COL_W-1:0] idx,
        input logic [COL_W-1:0] mask,
        input logic             ilv
    );
        if (ilv) return base ^ (idx & mask);
        return (base & ~mask) | ((base + idx) & mask);
    endfunction

    always_comb begin
        is_wr    = (cmd == CMD_WRITE);
        single   = is_wr && write_single;
        eff_blg  = single ? 2'd0 : len_log2;
        eff_full = full_page && !single;
        len_m1   = (COL_W'(1) << blg_q) - COL_W'(1);
        mask_q   = full_q ? {COL_W{1'b1}} : len_m1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            start_q <= '0;
            idx_q   <= '0;
            blg_q   <= '0;
            full_q  <= 1'b0;
            ilv_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            unique case (cmd)
                CMD_READ, CMD_WRITE: begin
                    valid_q <= 1'b1;
                    addr_q  <= cmd_col;
                    start_q <= cmd_col;
                    idx_q   <= COL_W'(1);
                    wr_q    <= is_wr;
                    blg_q   <= eff_blg;
                    full_q  <= eff_full;
                    ilv_q   <= interleave;
                    last_q  <= !eff_full && (eff_blg == 2'd0);
                end
                CMD_TERM: begin
                    valid_q <= 1'b0;
                    last_q  <= 1'b0;
                end
                default: begin
                    if (valid_q) begin
                        if (last_q) begin
                            valid_q <= 1'b0;
                        end else begin
                            addr_q <= beat_addr(start_q, idx_q, mask_q, ilv_q);
                            idx_q  <= idx_q + COL_W'(1);
                            last_q <= !full_q && (idx_q == len_m1);
                        end
                    end
                end
            endcase
        end
    end

    assign col_valid = valid_q;
    assign col_addr  = addr_q;
    assign col_is_wr = wr_q;

    // R8: a new command lands its own start column on the next cycle
    p_start_column_r8: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_READ) || (cmd == CMD_WRITE)) |=>
            (valid_q && (addr_q == $past(cmd_col))));

    // R9: burst stop removes the beat after the registering edge
    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_TERM) |=> !valid_q);

    // R3: a continuing non-page burst never leaves its aligned block
    p_block_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_q && $past(valid_q) && ($past(cmd) == CMD_NOP) && !full_q) |->
            ((addr_q & ~mask_q) == ($past(addr_q) & ~mask_q)));

    // R2: a full-page burst keeps running while nothing stops it
    p_page_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_q && full_q && (cmd == CMD_NOP)) |=> valid_q);

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int MAX_LAT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       beat,
    input  logic [1:0] lat,
    output logic       rd_oe,
    output logic       rd_valid
);

    localparam int TAP_W = $clog2(MAX_LAT + 1);

    logic [MAX_LAT:1] sh_q;
    logic [MAX_LAT:0] taps;
    logic [TAP_W-1:0] lat_i;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[MAX_LAT-1:1], beat};
    end

    always_comb begin
        taps     = {sh_q, beat};
        lat_i    = TAP_W'(lat);
        rd_oe    = taps[lat_i - TAP_W'(1)];
        rd_valid = taps[lat_i];
    end

    // R5: every valid cycle is preceded by an output-enable cycle
    p_valid_trails_oe_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_oe));

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int COL_W   = 10,
    parameter int MAX_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [12:0]      mode_op,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] cmd_col,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_is_wr,
    output logic             rd_oe,
    output logic             rd_valid,
    output logic             mode_illegal
);

    burst_cfg_t cfg;
    cmd_e       cmd_i;
    logic       rd_beat;

    assign cmd_i   = cmd_e'(cmd);
    assign rd_beat = col_valid && !col_is_wr;

    sdr_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (mode_load),
        .op      (mode_op),
        .cfg     (cfg),
        .illegal (mode_illegal)
    );

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd_i),
        .cmd_col      (cmd_col),
        .len_log2     (cfg.len_log2),
        .full_page    (cfg.full_page),
        .interleave   (cfg.interleave),
        .write_single (cfg.write_single),
        .col_valid    (col_valid),
        .col_addr     (col_addr),
        .col_is_wr    (col_is_wr)
    );

    sdr_rd_pipe #(.MAX_LAT(MAX_LAT)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .beat     (rd_beat),
        .lat      (cfg.cas_lat),
        .rd_oe    (rd_oe),
        .rd_valid (rd_valid)
    );

    // R6: read strobes never start from a write beat
    p_no_oe_from_write_r6: assert property (@(posedge clk) disable iff (rst)
        (col_valid && col_is_wr && !rd_oe) |=> !(rd_oe && !$past(rd_beat) && (cfg.cas_lat == 2'd2)));

endmodule

// File: tb/tb_sdr_burst_seq.sv
module tb_sdr_burst_seq;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             mode_load;
    logic [12:0]      mode_op;
    logic [1:0]       cmd;
    logic [COL_W-1:0] cmd_col;
    logic             col_valid;
    logic [COL_W-1:0] col_addr;
    logic             col_is_wr;
    logic             rd_oe;
    logic             rd_valid;
    logic             mode_illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sdr_burst_seq #(.COL_W(COL_W), .MAX_LAT(3)) dut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_op(mode_op),
        .cmd(cmd), .cmd_col(cmd_col), .col_valid(col_valid), .col_addr(col_addr),
        .col_is_wr(col_is_wr), .rd_oe(rd_oe), .rd_valid(rd_valid),
        .mode_illegal(mode_illegal)
    );

    typedef struct packed {
        logic [12:0] op;
        logic        wr;
        logic [9:0]  col;
        logic [3:0]  len;
        logic [1:0]  lat;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{13'h020, 1'b0, 10'h005, 4'd1, 2'd2},
        '{13'h021, 1'b0, 10'h013, 4'd2, 2'd2},
        '{13'h022, 1'b0, 10'h03E, 4'd4, 2'd2},
        '{13'h033, 1'b0, 10'h105, 4'd8, 2'd3},
        '{13'h02B, 1'b0, 10'h2B5, 4'd8, 2'd2},
        '{13'h03A, 1'b0, 10'h00E, 4'd4, 2'd3},
        '{13'h022, 1'b1, 10'h041, 4'd4, 2'd2},
        '{13'h223, 1'b1, 10'h077, 4'd1, 2'd2},
        '{13'h223, 1'b0, 10'h077, 4'd8, 2'd2},
        '{13'h039, 1'b0, 10'h3FF, 4'd2, 2'd3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] model_addr(input logic [9:0] col, input int j,
                                              input int len, input bit ilv);
        int low;
        if (ilv) return col ^ 10'(j);
        low = int'(col) % len;
        return 10'(int'(col) - low + (low + j) % len);
    endfunction

    task automatic load_mode(input logic [12:0] op);
        @(negedge clk);
        mode_load = 1'b1;
        mode_op   = op;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    // Drives a command for one edge; returns just after it (beat 0 visible).
    task automatic issue(input logic [1:0] c, input logic [9:0] col);
        @(negedge clk);
        cmd     = c;
        cmd_col = col;
        @(negedge clk);
        cmd = 2'd0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        rst = 1'b1; mode_load = 1'b0; mode_op = '0; cmd = 2'd0; cmd_col = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10 col_valid", col_valid, 0);
        chk("R10 rd_oe", rd_oe, 0);
        chk("R10 rd_valid", rd_valid, 0);
        chk("R10 mode_illegal", mode_illegal, 0);
        chk("R10 col_is_wr", col_is_wr, 0);

        // R10: default mode is length 1, latency 2
        issue(2'd1, 10'h009);
        chk("R10 addr", col_addr, 10'h009);
        chk("R10 valid", col_valid, 1);
        @(negedge clk);
        chk("R10 len1 end", col_valid, 0);
        chk("R10 oe lat2", rd_oe, 1);
        chk("R10 valid not yet", rd_valid, 0);
        @(negedge clk);
        chk("R10 oe off", rd_oe, 0);
        chk("R10 data valid", rd_valid, 1);
        repeat (3) @(negedge clk);

        // Table of bursts: R1, R3, R4, R5, R6
        foreach (VECS[v]) begin
            vec_t t;
            int len;
            int lat;
            t   = VECS[v];
            len = int'(t.len);
            lat = int'(t.lat);
            load_mode(t.op);
            chk("R7 legal load", mode_illegal, 0);
            issue(t.wr ? 2'd2 : 2'd1, t.col);
            for (int j = 0; j < len + lat + 2; j++) begin
                bit in_b;
                in_b = (j < len);
                chk(t.wr ? "R6 length" : "R1 length", col_valid, in_b);
                if (in_b) begin
                    chk(t.op[3] ? "R4 order" : "R3 order", col_addr,
                        model_addr(t.col, j, len, t.op[3]));
                    chk("R8 type", col_is_wr, t.wr);
                end
                chk(t.wr ? "R6 no oe" : "R5 oe", rd_oe,
                    !t.wr && (j >= lat - 1) && (j < lat - 1 + len));
                chk(t.wr ? "R6 no valid" : "R5 valid", rd_valid,
                    !t.wr && (j >= lat) && (j < lat + len));
                @(negedge clk);
            end
        end

        // R2, R9: full page wraps, then burst stop drains reads
        load_mode(13'h027);
        issue(2'd1, 10'h3FD);
        for (int j = 0; j < 1030; j++) begin
            chk("R2 page run", col_valid, 1);
            chk("R2 page addr", col_addr, 10'((10'h3FD + j) % 1024));
            if (j < 1029) @(negedge clk);
        end
        cmd = 2'd3;
        @(negedge clk);
        cmd = 2'd0;
        chk("R9 stop", col_valid, 0);
        chk("R9 oe drain", rd_oe, 1);
        chk("R9 valid drain", rd_valid, 1);
        @(negedge clk);
        chk("R9 oe end", rd_oe, 0);
        chk("R9 valid last", rd_valid, 1);
        @(negedge clk);
        chk("R9 valid end", rd_valid, 0);
        chk("R9 still stopped", col_valid, 0);

        // R8: truncation by a write in the middle of a length-8 latency-3 read
        load_mode(13'h033);
        issue(2'd1, 10'h010);
        @(negedge clk);
        @(negedge clk);
        chk("R8 pre addr", col_addr, 10'h012);
        cmd = 2'd2; cmd_col = 10'h020;
        @(negedge clk);
        cmd = 2'd0;
        chk("R8 new start", col_addr, 10'h020);
        chk("R8 write type", col_is_wr, 1);
        chk("R8 oe from read", rd_oe, 1);
        @(negedge clk);
        chk("R8 next addr", col_addr, 10'h021);
        @(negedge clk);
        chk("R8 oe cut", rd_oe, 0);
        repeat (12) @(negedge clk);
        chk("R8 write done", col_valid, 0);

        // R7: rejected loads keep the length-4 sequential setting
        load_mode(13'h022);
        chk("R7 base legal", mode_illegal, 0);
        load_mode(13'h422); chk("R7 high bits", mode_illegal, 1);
        load_mode(13'h0A2); chk("R7 op mode bits", mode_illegal, 1);
        load_mode(13'h042); chk("R7 latency code", mode_illegal, 1);
        load_mode(13'h024); chk("R7 length code", mode_illegal, 1);
        load_mode(13'h02F); chk("R7 page interleaved", mode_illegal, 1);
        issue(2'd1, 10'h006);
        chk("R7 kept order0", col_addr, 10'h006);
        @(negedge clk); chk("R7 kept order1", col_addr, 10'h007);
        @(negedge clk); chk("R7 kept order2", col_addr, 10'h004);
        @(negedge clk); chk("R7 kept order3", col_addr, 10'h005);
        @(negedge clk); chk("R7 kept length", col_valid, 0);
        chk("R7 kept latency", rd_oe, 1);
        repeat (3) @(negedge clk);
        load_mode(13'h021);
        chk("R7 flag cleared", mode_illegal, 0);

        done = 1'b1;
        summary();
    end

endmodule